// File: doc/BRIEF.md
# Single-Step Non-Restoring Divider

This block is the data path for one step of a non-restoring binary division. It keeps a working dividend/remainder register and three status bits: the remainder sign bit (Q), the divisor sign bit (M) and a result bit (T). A caller first issues an initialise command, signed or unsigned. That command loads the register and sets up the three bits. The caller then issues one step command per quotient bit. Each step shifts the previous T into bit 0 of the register. It then adds the divisor to the register or subtracts it, and produces the next quotient bit in T.

The caller owns the sequencing. It issues the step commands, extracts the quotient bits that have been shifted in, and applies any final sign or remainder correction. The usual arrangement is as follows:
- The divisor is placed in the upper half of the divisor input.
- After sixteen steps the register's low half holds the earlier quotient bits and T holds the last one.
- The register's upper half holds the partial remainder, taken modulo 2^16.

Top module: `div_step_unit`

## Requirements
- R1: While reset is asserted, the register and Q, M and T all read zero.
- R2: A strobed unsigned-initialise command (op 2'b00) loads the register from `dividend_i` and clears Q, M and T on the next clock edge.
- R3: A strobed signed-initialise command (op 2'b01) loads the register from `dividend_i`. It sets Q to `dividend_i[31]` and M to `divisor_i[31]`, and sets T to 1 exactly when those two bits differ.
- R4: A step command (op 2'b10) leaves M unchanged. After the step, T is 1 exactly when the new Q equals M.
- R5: A step works as follows, and ignores `dividend_i`:
  - It takes the register shifted left by one, with the old T in bit 0.
  - It subtracts the divisor when the old Q equals M, and adds it otherwise.
  - The new Q is the bit shifted out, XOR the carry/borrow, XOR M.
- R6: Take an unsigned initialise with divisor D in bits 31:16 (bits 15:0 zero) and dividend X with X[31:16] < D. Sixteen steps after it, `{dividend_o[14:0], t_o}` equals X / D.
- R7: Take a signed initialise with a 16-bit signed divisor D in bits 31:16 and |X| < |D|·2^16. Sixteen steps after it, define the following, for i = 2..16:
  - Digits: digit 1 is -1 when the initial T was 1 and +1 otherwise. Digit i is +1 when the T after step i-1 was 1, and -1 otherwise.
  - Q = Σ digit_i·2^(16-i) and R = X − D·Q.
  - The checks are: |R| ≤ |D|; `dividend_o[31:16]` equals R mod 2^16; and `dividend_o[15:0]` holds the initial T and the first fifteen step T values, oldest in bit 15.
- R8: With no strobe, or with the reserved op 2'b11, the register and all three status bits hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 00 unsigned init, 01 signed init, 10 step, 11 reserved |
| divisor_i | input | 32 | Divisor operand |
| dividend_i | input | 32 | Value loaded into the register by the initialise commands |
| dividend_o | output | 32 | Working dividend/remainder register |
| q_o | output | 1 | Remainder sign status bit |
| m_o | output | 1 | Divisor sign status bit |
| t_o | output | 1 | Quotient/result bit |

## Verification
The following are checked by assertions on every cycle:
- the flag and register values after each initialise command;
- that M does not change across a step;
- the T relation after a step;
- that all state holds when idle or on the reserved op.

Whether the chain of add/subtract choices actually divides can only be shown by the bench's multi-step runs. The unsigned runs are compared with an integer quotient. The signed runs are checked two ways: the quotient digits rebuilt from T must leave a remainder bounded by the divisor, and that remainder must agree with the register's upper half.

// File: rtl/div_step_pkg.sv
package div_step_pkg;
  typedef enum logic [1:0] {
    DIV_OP_UINIT = 2'b00,
    DIV_OP_SINIT = 2'b01,
    DIV_OP_STEP  = 2'b10,
    DIV_OP_RSVD  = 2'b11
  } div_op_e;
endpackage

// File: rtl/div_init_flags.sv
module div_init_flags (
  input  logic signed_i,
  input  logic dvd_msb_i,
  input  logic dsr_msb_i,
  output logic q_o,
  output logic m_o,
  output logic t_o
);
  // unsigned init forces all flags low
  assign q_o = signed_i & dvd_msb_i;
  assign m_o = signed_i & dsr_msb_i;
  assign t_o = q_o ^ m_o;
endmodule

// File: rtl/div_step_alu.sv
module div_step_alu #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] rem_i,
  input  logic [DATA_W-1:0] dsr_i,
  input  logic              q_i,
  input  logic              m_i,
  input  logic              t_i,
  output logic [DATA_W-1:0] rem_o,
  output logic              q_o,
  output logic              t_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [MSB:0] shifted;
  logic [MSB:0] sum;
  logic         out_bit;
  logic         do_sub;
  logic         cy;
  logic         nq;

  always_comb begin
    out_bit = rem_i[MSB];
    shifted = {rem_i[MSB-1:0], t_i};
    do_sub  = (q_i == m_i);
    if (do_sub) begin
      sum = shifted - dsr_i;
      cy  = (sum > shifted);   // borrow out
    end else begin
      sum = shifted + dsr_i;
      cy  = (sum < shifted);   // carry out
    end
    // four-way new-Q selection keyed on divisor sign and shifted-out bit
    unique case ({m_i, out_bit})
      2'b00:   nq = cy;
      2'b01:   nq = ~cy;
      2'b10:   nq = ~cy;
      default: nq = cy;
    endcase
    rem_o = sum;
    q_o   = nq;
    t_o   = (nq == m_i);
  end
endmodule

// File: rtl/div_step_unit.sv
module div_step_unit
  import div_step_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [DATA_W-1:0] divisor_i,
  input  logic [DATA_W-1:0] dividend_i,
  output logic [DATA_W-1:0] dividend_o,
  output logic              q_o,
  output logic              m_o,
  output logic              t_o
);
  localparam int unsigned MSB = DATA_W - 1;

  div_op_e     op;
  logic [MSB:0] rem_q, rem_d, step_rem;
  logic         q_q, m_q, t_q, q_d, m_d, t_d;
  logic         init_q, init_m, init_t, step_q, step_t;

  assign op = div_op_e'(cmd_op_i);

  div_init_flags u_init (
    .signed_i  (op == DIV_OP_SINIT),
    .dvd_msb_i (dividend_i[MSB]),
    .dsr_msb_i (divisor_i[MSB]),
    .q_o       (init_q),
    .m_o       (init_m),
    .t_o       (init_t)
  );

  div_step_alu #(.DATA_W(DATA_W)) u_alu (
    .rem_i (rem_q),
    .dsr_i (divisor_i),
    .q_i   (q_q),
    .m_i   (m_q),
    .t_i   (t_q),
    .rem_o (step_rem),
    .q_o   (step_q),
    .t_o   (step_t)
  );

  always_comb begin
    rem_d = rem_q;
    q_d   = q_q;
    m_d   = m_q;
    t_d   = t_q;
    if (cmd_valid_i) begin
      unique case (op)
        DIV_OP_UINIT, DIV_OP_SINIT: begin
          rem_d = dividend_i;
          q_d   = init_q;
          m_d   = init_m;
          t_d   = init_t;
        end
        DIV_OP_STEP: begin
          rem_d = step_rem;
          q_d   = step_q;
          t_d   = step_t;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      q_q   <= 1'b0;
      m_q   <= 1'b0;
      t_q   <= 1'b0;
    end else begin
      rem_q <= rem_d;
      q_q   <= q_d;
      m_q   <= m_d;
      t_q   <= t_d;
    end
  end

  assign dividend_o = rem_q;
  assign q_o        = q_q;
  assign m_o        = m_q;
  assign t_o        = t_q;
endmodule

// File: rtl/div_step_unit_chk.sv
module div_step_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_op_i,
  input logic [DATA_W-1:0] divisor_i,
  input logic [DATA_W-1:0] dividend_i,
  input logic [DATA_W-1:0] dividend_o,
  input logic              q_o,
  input logic              m_o,
  input logic              t_o
);
  localparam int unsigned MSB = DATA_W - 1;

  a_r2_uinit_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'b00) |=>
      (!q_o && !m_o && !t_o && dividend_o == $past(dividend_i)));

  a_r3_sinit_signs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'b01) |=>
      (q_o == $past(dividend_i[MSB]) && m_o == $past(divisor_i[MSB]) &&
       t_o == (q_o != m_o) && dividend_o == $past(dividend_i)));

  a_r4_step_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'b10) |=>
      (m_o == $past(m_o) && t_o == (q_o == m_o)));

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i || cmd_op_i == 2'b11) |=>
      ($stable(dividend_o) && $stable(q_o) && $stable(m_o) && $stable(t_o)));
endmodule

bind div_step_unit div_step_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/div_step_unit_test.sv
module div_step_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = 2'b00;
  logic [31:0] divisor_i = '0;
  logic [31:0] dividend_i = '0;
  logic [31:0] dividend_o;
  logic        q_o, m_o, t_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit tt [17];

  always #4 clk_i = ~clk_i;

  div_step_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .divisor_i(divisor_i), .dividend_i(dividend_i), .dividend_o(dividend_o),
    .q_o(q_o), .m_o(m_o), .t_o(t_o)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic issue(bit vld, logic [1:0] op, logic [31:0] dsr, logic [31:0] dvd);
    cmd_valid_i = vld;
    cmd_op_i    = op;
    divisor_i   = dsr;
    dividend_i  = dvd;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic run_seq(bit sgn, logic [31:0] x, logic [31:0] dsr);
    issue(1'b1, sgn ? 2'b01 : 2'b00, dsr, x);
    tt[0] = t_o;
    for (int i = 1; i <= 16; i++) begin
      bit m_before;
      m_before = m_o;
      issue(1'b1, 2'b10, dsr, $urandom);
      tt[i] = t_o;
      chk(m_o == m_before && t_o == (q_o == m_o), "R4 step flags",
          {q_o, m_o, t_o}, {q_o, m_before, (q_o == m_before)});
    end
  endtask

  task automatic check_u(logic [31:0] x, logic [15:0] d);
    logic [15:0] act;
    logic [31:0] exp;
    run_seq(1'b0, x, {d, 16'h0});
    act = {dividend_o[14:0], t_o};
    exp = x / {16'h0, d};
    chk(act == exp[15:0], "R6 unsigned quotient", act, exp);
  endtask

  task automatic check_s(logic [31:0] x, logic signed [15:0] d);
    longint qn, r, ad;
    logic [15:0] low_exp;
    run_seq(1'b1, x, {d, 16'h0});
    qn = 0;
    for (int i = 1; i <= 16; i++) begin
      longint dig;
      if (i == 1) dig = tt[0] ? -1 : 1;
      else        dig = tt[i-1] ? 1 : -1;
      qn += dig * (longint'(1) << (16 - i));
    end
    r  = longint'($signed(x)) - longint'(d) * qn;
    ad = (d < 0) ? -longint'(d) : longint'(d);
    chk(r <= ad && r >= -ad, "R7 remainder bound", r, ad);
    chk(r[15:0] == dividend_o[31:16], "R7 remainder bits", dividend_o[31:16], r[15:0]);
    for (int i = 0; i < 16; i++) low_exp[15-i] = tt[i];
    chk(dividend_o[15:0] == low_exp, "R7 quotient history", dividend_o[15:0], low_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk_i);
    chk(dividend_o == 0 && !q_o && !m_o && !t_o, "R1 reset state",
        {dividend_o, q_o, m_o, t_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3: differing signs, then matching signs
    issue(1'b1, 2'b01, 32'h0001_0000, 32'h8000_1234);
    chk(q_o && !m_o && t_o && dividend_o == 32'h8000_1234, "R3 signed init differ",
        {dividend_o, q_o, m_o, t_o}, {32'h8000_1234, 3'b101});
    issue(1'b1, 2'b01, 32'hFFFF_0000, 32'h9000_0000);
    chk(q_o && m_o && !t_o, "R3 signed init match", {q_o, m_o, t_o}, 3'b110);

    // R8: idle, then reserved op
    issue(1'b0, 2'b10, 32'h1234_0000, 32'h5555_5555);
    chk(dividend_o == 32'h9000_0000 && q_o && m_o && !t_o, "R8 idle hold",
        {dividend_o, q_o, m_o, t_o}, {32'h9000_0000, 3'b110});
    issue(1'b1, 2'b11, 32'h1234_0000, 32'h5555_5555);
    chk(dividend_o == 32'h9000_0000 && q_o && m_o && !t_o, "R8 reserved op hold",
        {dividend_o, q_o, m_o, t_o}, {32'h9000_0000, 3'b110});

    // R2: clears flags left set by the signed init
    issue(1'b1, 2'b00, 32'h8000_0000, 32'hDEAD_BEEF);
    chk(!q_o && !m_o && !t_o && dividend_o == 32'hDEAD_BEEF, "R2 unsigned init",
        {dividend_o, q_o, m_o, t_o}, {32'hDEAD_BEEF, 3'b000});

    // R5 directed single steps
    issue(1'b1, 2'b00, 32'h0001_0000, 32'h0001_0000);
    issue(1'b1, 2'b10, 32'h0001_0000, 32'hFFFF_FFFF);
    chk(dividend_o == 32'h0001_0000 && !q_o && t_o, "R5 subtract no borrow",
        {dividend_o, q_o, t_o}, {32'h0001_0000, 2'b01});
    issue(1'b1, 2'b00, 32'h0001_0000, 32'h0000_0000);
    issue(1'b1, 2'b10, 32'h0001_0000, 32'h0);
    chk(dividend_o == 32'hFFFF_0000 && q_o && !t_o, "R5 subtract with borrow",
        {dividend_o, q_o, t_o}, {32'hFFFF_0000, 2'b10});
    issue(1'b1, 2'b01, 32'h0001_0000, 32'h8000_0000);
    issue(1'b1, 2'b10, 32'h0001_0000, 32'h0);
    chk(dividend_o == 32'h0001_0001 && q_o && !t_o, "R5 add path",
        {dividend_o, q_o, t_o}, {32'h0001_0001, 2'b10});

    // R6 directed and random
    check_u(32'h0000_0000, 16'h0001);
    check_u(32'h0000_FFFF, 16'h0001);
    check_u(32'hFFFE_FFFF, 16'hFFFF);
    check_u(32'h0000_1234, 16'h8000);
    for (int n = 0; n < 40; n++) begin
      logic [15:0] d;
      logic [15:0] hi;
      d  = 16'($urandom_range(1, 65535));
      hi = 16'($urandom_range(0, int'(d) - 1));
      check_u({hi, 16'($urandom)}, d);
    end

    // R7 directed and random
    check_s(32'h0000_0000, 16'sd1);
    check_s(32'hFFFF_FFFF, -16'sd1);
    check_s(32'h7FFE_FFFF, 16'sh7FFF);
    check_s(32'h8001_0000, -16'sh8000);
    check_s(32'h0000_0001, -16'sd3);
    for (int n = 0; n < 40; n++) begin
      int ad, rr;
      logic signed [15:0] d;
      ad = $urandom_range(1, 32768);
      d  = ($urandom_range(0, 1) == 1) ? 16'(-ad) : 16'(ad);
      if (ad == 32768) d = -16'sh8000;
      rr = $urandom_range(0, 2 * ad - 2) - (ad - 1);
      check_s(32'(rr * 65536) + {16'h0, 16'($urandom)}, d);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule